// File: doc/BRIEF.md
# Deep Sleep Residency Counter

This block measures how long the processor spends in its deepest sleep states. It holds a count field that advances once for each tick of a shared power-management timer enable. The count only advances while the active-low processor stop input is asserted. Software reads the result as a 32-bit read-only word. A single writable mode bit sits in that word.

The mode bit decides what happens when software reads one of the registers that request level-3 or level-4 sleep entry. That read reaches the block as a one-cycle pulse.
- With the mode bit clear, the pulse empties the count. The next sleep period is then measured from zero.
- With the mode bit set, the pulse is ignored and the count keeps accumulating.

The count wraps around like the timer it follows. Software must notice a wrap itself. The counter is emptied only by that entry pulse or by hardware reset.

Top module: `sleep_residency_ctr`

## Requirements
- R1: While `rst_n` is low at a clock edge, the whole register word becomes 0. This includes the count field and the mode bit. After reset is released, `reg_rdata` reads 32'h0000_0000 until something changes it.
- R2: When `tick_en` is 1 and `cpu_stop_n` is 0 at a clock edge, the count field (bits CNT_W-1:0, 23:0 by default) goes up by exactly one at that edge. This holds unless R5 applies.
- R3: When `cpu_stop_n` is 1, the count field holds its value, whatever `tick_en` is.
- R4: When `tick_en` is 0, the count field holds its value, whatever `cpu_stop_n` is.
- R5: When `entry_rd` is 1 at an edge and the mode bit (bit 31) reads 0, the count field is 0 after that edge.
- R6: When the mode bit reads 1, `entry_rd` has no effect. The count holds or advances exactly as R2 to R4 say.
- R7: When a tick while asleep and a clearing entry read (R5) occur in the same cycle, the clear wins and the count is 0.
- R8: The count wraps from all ones to 0 on the next qualifying tick and then keeps counting. Its top bit is not held once set.
- R9: A write (`reg_wr_en` = 1) loads bit 31 of `reg_wdata` into the mode bit. The new value is visible from the next cycle. All other write data bits are ignored and leave the count unchanged. Bits 30:CNT_W always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| tick_en | input | 1 | One-cycle tick from the power-management timer |
| cpu_stop_n | input | 1 | Active-low processor stop; low means deep sleep |
| entry_rd | input | 1 | Pulse marking a read of a level-3/level-4 entry register |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data; only bit 31 is used |
| reg_rdata | output | 32 | Register read word: mode at 31, zeros, count in CNT_W-1:0 |

## Verification
The bound checker watches several rules on every cycle:
- the step-by-one rule while asleep;
- the hold rules when awake or without a tick;
- the clear after an entry read in clearing mode, including when a tick lands in the same cycle;
- the ignored entry read in keeping mode;
- the mode write taking effect;
- the reserved bits reading zero.

Some behaviour only the directed scenarios show:
- reaching exact accumulated values over mixed patterns;
- wrapping at the full count and then continuing;
- the way the register behaves after a reset in the middle of a run.

The bench shrinks the count width to ten bits so that the wrap fits within a short run.

// File: rtl/srcnt_pkg.sv
// Package: shared constants and types for the sleep residency counter.
// Assumes a 32-bit register word with the mode bit at its top position.
package srcnt_pkg;
    localparam int REG_W    = 32;
    localparam int MODE_POS = REG_W - 1;

    // Behaviour of the count on a sleep-entry register read
    typedef enum logic {
        MODE_CLEAR_ON_ENTRY = 1'b0,
        MODE_KEEP_ON_ENTRY  = 1'b1
    } res_mode_e;
endpackage

// File: rtl/srcnt_mode_reg.sv
// Module: holds the residency mode bit.
// Loads the bit from the write port when the write strobe is high.
// Assumes software sets it once at initialization, though any write is honoured.
module srcnt_mode_reg
    import srcnt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      wr_bit,
    output res_mode_e mode_o
);
    // Mode storage with synchronous reset to clear-on-entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= MODE_CLEAR_ON_ENTRY;
        end else if (wr_en) begin
            mode_o <= res_mode_e'(wr_bit);
        end
    end
endmodule

// File: rtl/srcnt_counter.sv
// Module: the wrapping residency count.
// Counts timer ticks taken while asleep. A clear request has priority over a tick.
// Assumes tick_en is a single-cycle enable from the shared timer.
module srcnt_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             asleep,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count: clear first, then step on a qualified tick (wraps naturally)
    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick_en && asleep) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // Count register, emptied only by hardware reset or the clear request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/srcnt_rdmux.sv
// Module: assembles the 32-bit read word from the mode bit and the count.
// Reserved bits between them are tied to zero.
// Assumes CNT_W is below the mode bit position.
module srcnt_rdmux
    import srcnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  res_mode_e        mode_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [REG_W-1:0] rdata_o
);
    localparam int RSV_W = MODE_POS - CNT_W;

    // Count field and mode bit placement
    always_comb begin
        rdata_o[CNT_W-1:0] = cnt_i;
        rdata_o[MODE_POS]  = logic'(mode_i);
    end

    // Reserved field exists only when the count leaves a gap below the mode bit
    generate
        if (RSV_W > 0) begin : g_rsv
            always_comb rdata_o[MODE_POS-1:CNT_W] = '0;
        end
    endgenerate
endmodule

// File: rtl/sleep_residency_ctr.sv
// Module: top of the deep sleep residency counter.
// Joins the mode register, the count and the read assembly.
// An entry-register read clears the count only in clear-on-entry mode.
// Assumes all inputs are synchronous to clk.
module sleep_residency_ctr
    import srcnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        cpu_stop_n,
    input  logic        entry_rd,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    res_mode_e        mode;
    logic [CNT_W-1:0] cnt;
    logic             clr_req;
    logic             asleep;
    logic             unused_wdata;

    // Only the mode bit of the write word is meaningful
    assign unused_wdata = ^reg_wdata[MODE_POS-1:0];

    // Sleep qualifier and mode-dependent clear request
    always_comb begin
        asleep  = !cpu_stop_n;
        clr_req = entry_rd && (mode == MODE_CLEAR_ON_ENTRY);
    end

    srcnt_mode_reg i_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .wr_bit (reg_wdata[MODE_POS]),
        .mode_o (mode)
    );

    srcnt_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .asleep  (asleep),
        .clr     (clr_req),
        .cnt_o   (cnt)
    );

    srcnt_rdmux #(.CNT_W(CNT_W)) i_rd (
        .mode_i  (mode),
        .cnt_i   (cnt),
        .rdata_o (reg_rdata)
    );
endmodule

// File: rtl/sleep_residency_ctr_chk.sv
// Checker: port-level properties of the residency counter, bound to the top.
module sleep_residency_ctr_chk #(
    parameter int CNT_W = 24
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        cpu_stop_n,
    input logic        entry_rd,
    input logic        reg_wr_en,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata
);
    logic             mode_q;
    logic             clr_now;
    logic [CNT_W-1:0] cnt_v;
    logic             unused_chk;

    assign mode_q     = reg_rdata[31];
    assign cnt_v      = reg_rdata[CNT_W-1:0];
    assign clr_now    = entry_rd && !mode_q;
    assign unused_chk = ^reg_wdata[30:0];

    // R2: qualified tick steps the count by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cpu_stop_n && !clr_now) |=>
        (cnt_v == CNT_W'($past(cnt_v) + 1'b1)));

    // R3: awake means no change unless cleared
    a_r3_hold_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stop_n && !clr_now) |=> $stable(cnt_v));

    // R4: no tick means no change unless cleared
    a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !clr_now) |=> $stable(cnt_v));

    // R5, R7: entry read in clear mode empties the count, tick or not
    a_r5_entry_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (cnt_v == '0));

    // R6: entry read in keep mode leaves an idle count alone
    a_r6_keep_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_rd && mode_q && !tick_en) |=> $stable(cnt_v));

    // R9: mode write lands one cycle later
    a_r9_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (mode_q == $past(reg_wdata[31])));

    // R9: reserved bits read zero
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[30:CNT_W] == '0);
endmodule

bind sleep_residency_ctr sleep_residency_ctr_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .cpu_stop_n (cpu_stop_n),
    .entry_rd   (entry_rd),
    .reg_wr_en  (reg_wr_en),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata)
);

// File: tb/test_sleep_residency_ctr.sv
module test_sleep_residency_ctr;
    localparam int CW = 10;
    localparam logic [31:0] FULL = (32'h1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        cpu_stop_n = 1'b1;
    logic        entry_rd = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sleep_residency_ctr #(.CNT_W(CW)) i_sleep_residency_ctr (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_stop_n(cpu_stop_n),
        .entry_rd(entry_rd), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One clock with given inputs; returns at the next falling edge
    task automatic cyc(input logic t, input logic s_n, input logic e);
        tick_en = t; cpu_stop_n = s_n; entry_rd = e;
        @(negedge clk);
        tick_en = 1'b0; cpu_stop_n = 1'b1; entry_rd = 1'b0;
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic zero_count();
        wr(32'h0);
        cyc(1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_reset();
        tick_en = 1'b1; cpu_stop_n = 1'b0;
        repeat (3) @(negedge clk);
        tick_en = 1'b0; cpu_stop_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset word", reg_rdata, 32'h0);
    endtask

    task automatic t_count_asleep();
        zero_count();
        repeat (5) cyc(1'b1, 1'b0, 1'b0);
        check("R2 five ticks", reg_rdata, 32'd5);
        for (int i = 0; i < 6; i++) cyc(i[0] == 1'b0, 1'b0, 1'b0);
        check("R2 R4 alternating ticks", reg_rdata, 32'd8);
    endtask

    task automatic t_gates();
        repeat (4) cyc(1'b1, 1'b1, 1'b0);
        check("R3 awake ticks ignored", reg_rdata, 32'd8);
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        check("R4 asleep without tick", reg_rdata, 32'd8);
    endtask

    task automatic t_clear_mode0();
        cyc(1'b0, 1'b1, 1'b1);
        check("R5 entry read clears", reg_rdata, 32'd0);
        repeat (2) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        check("R5 clear while asleep", reg_rdata, 32'd0);
    endtask

    task automatic t_keep_mode();
        zero_count();
        repeat (3) cyc(1'b1, 1'b0, 1'b0);
        wr(32'h8000_00FF);
        check("R9 mode set, low data ignored", reg_rdata, 32'h8000_0003);
        cyc(1'b0, 1'b1, 1'b1);
        check("R6 entry read ignored", reg_rdata, 32'h8000_0003);
        cyc(1'b1, 1'b0, 1'b1);
        check("R6 entry read with tick", reg_rdata, 32'h8000_0004);
        wr(32'h7F00_0ABC);
        check("R9 mode cleared, reserved zero", reg_rdata, 32'h0000_0004);
    endtask

    task automatic t_clear_wins();
        zero_count();
        repeat (2) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        check("R7 clear beats tick", reg_rdata, 32'd0);
    endtask

    task automatic t_rollover();
        zero_count();
        for (int i = 0; i < int'(FULL); i++) cyc(1'b1, 1'b0, 1'b0);
        check("R8 full count", reg_rdata, FULL);
        cyc(1'b1, 1'b0, 1'b0);
        check("R8 wrap to zero", reg_rdata, 32'd0);
        cyc(1'b1, 1'b0, 1'b0);
        check("R8 counts after wrap", reg_rdata, 32'd1);
    endtask

    task automatic t_midrun_reset();
        wr(32'h8000_0000);
        repeat (6) cyc(1'b1, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", reg_rdata, 32'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_count_asleep();
        t_gates();
        t_clear_mode0();
        t_keep_mode();
        t_clear_wins();
        t_rollover();
        t_midrun_reset();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule